// File: doc/BRIEF.md
# Pause Frame Receiver and Transmit Hold Timer

This block sits beside the receive path of a full-duplex Ethernet MAC and watches the incoming byte stream for MAC control pause frames. It tracks each frame from its start strobe to its end strobe. As the header bytes go past, it compares them on the fly against the reserved flow-control multicast address and the station's own address, the MAC control type value and the pause opcode. It also captures the 16-bit pause quanta. A frame that qualifies in every respect produces a single-cycle indication, and a decision on whether the frame should also be handed to the receive FIFO.

A qualifying frame loads a pause counter with its quanta. Each pulse on the slot-time input (one per 512 bit times) counts it down, and it holds at zero. While the count is nonzero, the transmit side is told not to start new data frames. A frame already on the wire and the station's own flow-control frames are never held back. A new pause frame reloads the counter at any time, and a zero quanta releases the hold at once.

Top module: `pause_rx_timer`

## Requirements
- R1: A frame qualifies only if its six destination bytes (first byte on the wire = bits 47:40) equal 01-80-C2-00-00-01 or equal `station_addr`; any other destination is ignored.
- R2: A frame qualifies only if bytes 12 and 13 are 0x88, 0x08 and bytes 14 and 15 are 0x00, 0x01 (byte 0 = first byte after `rx_sof`); the quanta is taken from bytes 16 (high) and 17 (low).
- R3: A frame qualifies only if exactly 64 valid bytes lie between `rx_sof` and `rx_eof` inclusive and `rx_crc_ok` is high with the last byte; otherwise it changes nothing.
- R4: For each qualifying frame `pause_rx_pulse` is high for exactly one cycle, the cycle after the last byte is taken. It is produced only when `cfg_tx_fc_en` was high with that last byte.
- R5: The cycle after `pause_rx_pulse`, the counter holds the quanta and `paused` equals (count != 0). Each `slot_tick` lowers a nonzero count by one, and the count holds at zero. A load takes priority over a tick in the same cycle, and without a tick or a load the count is unchanged.
- R6: A later qualifying frame reloads the counter with its own quanta, whatever count remains.
- R7: A qualifying frame with quanta zero drops `paused` immediately.
- R8: `tx_inhibit` is high only while `paused` is high, `tx_busy` is low and `tx_fc_sel` is low.
- R9: `fwd_to_fifo` is high only together with `pause_rx_pulse`. It is high when `fifo_room` was high with the last byte and either the destination was `station_addr` or `cfg_reject_mc` was low.
- R10: While `rst_n` is low, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | `rx_data` carries a byte this cycle |
| rx_sof | input | 1 | First byte of a frame (with `rx_valid`) |
| rx_eof | input | 1 | Last byte of a frame (with `rx_valid`) |
| rx_data | input | 8 | Received byte |
| rx_crc_ok | input | 1 | Frame check passed, valid with `rx_eof` |
| station_addr | input | 48 | Station individual address, bits 47:40 sent first |
| cfg_tx_fc_en | input | 1 | Enables pause detection |
| cfg_reject_mc | input | 1 | Do not forward multicast-addressed pause frames |
| fifo_room | input | 1 | Receive FIFO can take a frame |
| slot_tick | input | 1 | One pulse per slot time |
| tx_busy | input | 1 | A transmit frame is in progress |
| tx_fc_sel | input | 1 | The next frame to start is the station's own flow-control frame |
| tx_inhibit | output | 1 | Do not start a new data frame |
| fwd_to_fifo | output | 1 | Pass the recognised pause frame to the FIFO |
| paused | output | 1 | Pause count is nonzero |
| pause_rx_pulse | output | 1 | A pause frame was recognised |

## Verification
The properties assume that `rx_sof` and `rx_eof` are raised only together with `rx_valid`, and that the configuration bits, `fifo_room` and `station_addr` are steady around the end of a frame. Every frame the stimulus sends is a complete, contiguous burst. Configuration changes, ticks and transmit-side inputs are applied only in the idle gaps between frames. The hold counter is observed only through `paused`, so quanta values are kept small. Tick counts are then chosen so that an early or late release shows up at the port.

// File: rtl/pfr_pkg.sv
package pfr_pkg;
  localparam logic [47:0] FC_MCAST_ADDR = 48'h0180_C200_0001;
  localparam logic [31:0] HDR_WORD      = 32'h8808_0001;
  localparam int          QUANTA_W      = 16;
  localparam int          DA_BYTES      = 6;
  localparam int          HDR_FIRST     = 12;
  localparam int          HDR_LAST      = 15;
  localparam int          QUANTA_HI     = 16;
  localparam int          QUANTA_LO     = 17;

  function automatic logic [7:0] addr_byte(input logic [47:0] a, input int k);
    logic [47:0] s;
    s = a >> (8 * (5 - k));
    return s[7:0];
  endfunction

  function automatic logic [7:0] hdr_byte(input int k);
    logic [31:0] s;
    s = HDR_WORD >> (8 * (3 - k));
    return s[7:0];
  endfunction
endpackage

// File: rtl/pfr_rst_sync.sv
module pfr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/pfr_parser.sv
module pfr_parser
  import pfr_pkg::*;
#(
  parameter int FRAME_BYTES = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rx_valid,
  input  logic                rx_sof,
  input  logic                rx_eof,
  input  logic [7:0]          rx_data,
  input  logic                rx_crc_ok,
  input  logic [47:0]         station_addr,
  input  logic                cfg_fc_en,
  input  logic                cfg_reject_mc,
  input  logic                fifo_room,
  output logic                evt_valid,
  output logic                evt_fwd,
  output logic [QUANTA_W-1:0] evt_quanta
);
  localparam int IW = $clog2(FRAME_BYTES) + 1;
  localparam logic [IW-1:0] IDX_MAX  = '1;
  localparam logic [IW-1:0] IDX_LAST = IW'(FRAME_BYTES - 1);

  logic [IW-1:0]       idx_q, idx_n, cur_idx;
  logic                act_q, act_n;
  logic                mc_q, mc_n, uc_q, uc_n, hdr_q, hdr_n;
  logic [QUANTA_W-1:0] qnt_q, qnt_n;
  logic                ev_q, ev_n, fwd_q, fwd_n;
  logic [QUANTA_W-1:0] evq_q, evq_n;
  logic                take;
  int                  pos;

  always_comb begin
    take    = rx_valid & (rx_sof | act_q);
    cur_idx = rx_sof ? '0 : idx_q;
    pos     = int'(cur_idx);
    idx_n   = idx_q;
    act_n   = act_q;
    mc_n    = mc_q;
    uc_n    = uc_q;
    hdr_n   = hdr_q;
    qnt_n   = qnt_q;
    ev_n    = 1'b0;
    fwd_n   = 1'b0;
    evq_n   = evq_q;
    if (take) begin
      if (rx_sof) begin
        mc_n  = 1'b1;
        uc_n  = 1'b1;
        hdr_n = 1'b1;
      end
      if (pos < DA_BYTES) begin
        mc_n = mc_n & (rx_data == addr_byte(FC_MCAST_ADDR, pos));
        uc_n = uc_n & (rx_data == addr_byte(station_addr, pos));
      end
      if (pos >= HDR_FIRST && pos <= HDR_LAST)
        hdr_n = hdr_n & (rx_data == hdr_byte(pos - HDR_FIRST));
      if (pos == QUANTA_HI) qnt_n[15:8] = rx_data;
      if (pos == QUANTA_LO) qnt_n[7:0]  = rx_data;
      idx_n = (cur_idx == IDX_MAX) ? cur_idx : cur_idx + 1'b1;
      act_n = ~rx_eof;
      if (rx_eof) begin
        ev_n  = cfg_fc_en & rx_crc_ok & (cur_idx == IDX_LAST) & (mc_n | uc_n) & hdr_n;
        fwd_n = ev_n & fifo_room & (uc_n | ~cfg_reject_mc);
        evq_n = qnt_n;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      act_q <= 1'b0;
      mc_q  <= 1'b0;
      uc_q  <= 1'b0;
      hdr_q <= 1'b0;
      qnt_q <= '0;
      ev_q  <= 1'b0;
      fwd_q <= 1'b0;
      evq_q <= '0;
    end else begin
      idx_q <= idx_n;
      act_q <= act_n;
      mc_q  <= mc_n;
      uc_q  <= uc_n;
      hdr_q <= hdr_n;
      qnt_q <= qnt_n;
      ev_q  <= ev_n;
      fwd_q <= fwd_n;
      evq_q <= evq_n;
    end
  end

  assign evt_valid  = ev_q;
  assign evt_fwd    = fwd_q;
  assign evt_quanta = evq_q;
endmodule

// File: rtl/pfr_timer.sv
module pfr_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          tick,
  output logic          paused
);
  logic [CW-1:0] cnt_q, cnt_n;
  logic          cnt_en;

  always_comb begin
    cnt_en = load | (tick & (cnt_q != '0));
    cnt_n  = load ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  assign paused = (cnt_q != '0);
endmodule

// File: rtl/pause_rx_timer.sv
module pause_rx_timer
  import pfr_pkg::*;
#(
  parameter int FRAME_BYTES = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  input  logic        rx_sof,
  input  logic        rx_eof,
  input  logic [7:0]  rx_data,
  input  logic        rx_crc_ok,
  input  logic [47:0] station_addr,
  input  logic        cfg_tx_fc_en,
  input  logic        cfg_reject_mc,
  input  logic        fifo_room,
  input  logic        slot_tick,
  input  logic        tx_busy,
  input  logic        tx_fc_sel,
  output logic        tx_inhibit,
  output logic        fwd_to_fifo,
  output logic        paused,
  output logic        pause_rx_pulse
);
  logic                core_rst_n;
  logic                evt_valid, evt_fwd;
  logic [QUANTA_W-1:0] evt_quanta;

  pfr_rst_sync #(.STAGES(SYNC_STAGES)) rst_i (
    .clk(clk), .arst_n(rst_n), .srst_n(core_rst_n)
  );

  pfr_parser #(.FRAME_BYTES(FRAME_BYTES)) parse_i (
    .clk(clk), .rst_n(core_rst_n),
    .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
    .rx_data(rx_data), .rx_crc_ok(rx_crc_ok),
    .station_addr(station_addr), .cfg_fc_en(cfg_tx_fc_en),
    .cfg_reject_mc(cfg_reject_mc), .fifo_room(fifo_room),
    .evt_valid(evt_valid), .evt_fwd(evt_fwd), .evt_quanta(evt_quanta)
  );

  pfr_timer #(.CW(QUANTA_W)) timer_i (
    .clk(clk), .rst_n(core_rst_n),
    .load(evt_valid), .load_val(evt_quanta), .tick(slot_tick),
    .paused(paused)
  );

  assign pause_rx_pulse = evt_valid;
  assign fwd_to_fifo    = evt_fwd;
  assign tx_inhibit     = paused & ~tx_busy & ~tx_fc_sel;
endmodule

// File: rtl/pfr_checker.sv
module pfr_checker (
  input logic clk,
  input logic rst_n,
  input logic cfg_tx_fc_en,
  input logic slot_tick,
  input logic tx_busy,
  input logic tx_fc_sel,
  input logic tx_inhibit,
  input logic fwd_to_fifo,
  input logic paused,
  input logic pause_rx_pulse
);
  a_r8_busy_not_held: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy |-> !tx_inhibit);
  a_r8_own_fc_free: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fc_sel |-> !tx_inhibit);
  a_r8_hold_needs_pause: assert property (@(posedge clk) disable iff (!rst_n)
    tx_inhibit |-> paused);
  a_r5_quiet_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!pause_rx_pulse && !slot_tick) |=> $stable(paused));
  a_r9_fwd_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_to_fifo |-> pause_rx_pulse);
  a_r4_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    pause_rx_pulse |-> $past(cfg_tx_fc_en));
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pause_rx_pulse |=> !pause_rx_pulse);
endmodule

bind pause_rx_timer pfr_checker chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_tx_fc_en(cfg_tx_fc_en),
  .slot_tick(slot_tick), .tx_busy(tx_busy), .tx_fc_sel(tx_fc_sel),
  .tx_inhibit(tx_inhibit), .fwd_to_fifo(fwd_to_fifo),
  .paused(paused), .pause_rx_pulse(pause_rx_pulse)
);

// File: tb/pause_rx_timer_tb_top.sv
`timescale 1ns/1ps
module pause_rx_timer_tb_top;
  localparam logic [47:0] MC  = 48'h0180_C200_0001;
  localparam logic [47:0] OWN = 48'h0012_3456_789A;
  localparam logic [47:0] SRC = 48'h00AA_BBCC_DDEE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 0, rx_sof = 0, rx_eof = 0, rx_crc_ok = 0;
  logic [7:0] rx_data = '0;
  logic cfg_tx_fc_en = 1, cfg_reject_mc = 0, fifo_room = 1, slot_tick = 0;
  logic tx_busy = 0, tx_fc_sel = 0;
  logic tx_inhibit, fwd_to_fifo, paused, pause_rx_pulse;

  int n_vec = 0, n_bad = 0;
  logic exp_q[$];

  always #5 clk = ~clk;

  pause_rx_timer dut_i (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
    .rx_eof(rx_eof), .rx_data(rx_data), .rx_crc_ok(rx_crc_ok),
    .station_addr(OWN), .cfg_tx_fc_en(cfg_tx_fc_en),
    .cfg_reject_mc(cfg_reject_mc), .fifo_room(fifo_room),
    .slot_tick(slot_tick), .tx_busy(tx_busy), .tx_fc_sel(tx_fc_sel),
    .tx_inhibit(tx_inhibit), .fwd_to_fifo(fwd_to_fifo),
    .paused(paused), .pause_rx_pulse(pause_rx_pulse)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (pause_rx_pulse === 1'b1) begin
      if (exp_q.size() == 0) check("R4 unexpected pause pulse", 1'b1, 1'b0);
      else check("R9 forward decision", fwd_to_fifo, exp_q.pop_front());
    end
  end

  function automatic logic [7:0] fbyte(input int i, input logic [47:0] da,
                                       input logic [15:0] ty, input logic [15:0] op,
                                       input logic [15:0] q);
    if (i < 6)  return da[8*(5-i) +: 8];
    if (i < 12) return SRC[8*(11-i) +: 8];
    if (i == 12) return ty[15:8];
    if (i == 13) return ty[7:0];
    if (i == 14) return op[15:8];
    if (i == 15) return op[7:0];
    if (i == 16) return q[15:8];
    if (i == 17) return q[7:0];
    return 8'h00;
  endfunction

  task automatic send(input logic [47:0] da, input logic [15:0] ty, input logic [15:0] op,
                      input logic [15:0] q, input int len, input logic crc);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1; rx_sof = (i == 0); rx_eof = (i == len - 1);
      rx_crc_ok = crc; rx_data = fbyte(i, da, ty, op, q);
    end
    @(negedge clk);
    rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_crc_ok = 0; rx_data = '0;
    repeat (2) @(negedge clk);
  endtask

  task automatic pause_frame(input logic [47:0] da, input logic [15:0] q, input logic fwd);
    exp_q.push_back(fwd);
    send(da, 16'h8808, 16'h0001, q, 64, 1'b1);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); slot_tick = 1;
      @(negedge clk); slot_tick = 0;
    end
  endtask

  task automatic finish_run();
    if (exp_q.size() != 0) check("R4 missing pause pulse", 1'b0, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #1500000;
    check("watchdog expired", 1'b0, 1'b1);
    finish_run();
  end

  initial begin
    #23;
    check("R10 reset paused", paused, 1'b0);
    check("R10 reset pulse", pause_rx_pulse, 1'b0);
    check("R10 reset fwd", fwd_to_fifo, 1'b0);
    check("R10 reset inhibit", tx_inhibit, 1'b0);
    @(negedge clk); rst_n = 1;
    repeat (5) @(negedge clk);

    pause_frame(MC, 16'd3, 1'b1);
    check("R5 paused after load", paused, 1'b1);
    ticks(2); check("R5 still paused at 1", paused, 1'b1);
    ticks(1); check("R5 released at 0", paused, 1'b0);
    ticks(1); check("R5 holds at zero", paused, 1'b0);

    cfg_reject_mc = 1;
    pause_frame(OWN, 16'd5, 1'b1);
    ticks(1);
    pause_frame(OWN, 16'd2, 1'b1);
    ticks(1); check("R6 reload count 1 left", paused, 1'b1);
    ticks(1); check("R6 reload expired", paused, 1'b0);

    pause_frame(MC, 16'd4, 1'b0);
    check("R9 rejected multicast still pauses", paused, 1'b1);
    cfg_reject_mc = 0;
    pause_frame(MC, 16'd0, 1'b1);
    check("R7 zero quanta releases", paused, 1'b0);

    pause_frame(OWN, 16'd10, 1'b1);
    send(MC, 16'h8808, 16'h0001, 16'd0, 64, 1'b0);
    check("R3 bad crc ignored", paused, 1'b1);
    send(MC, 16'h8808, 16'h0001, 16'd0, 63, 1'b1);
    check("R3 short frame ignored", paused, 1'b1);
    send(MC, 16'h8808, 16'h0001, 16'd0, 65, 1'b1);
    check("R3 long frame ignored", paused, 1'b1);
    send(MC, 16'h0800, 16'h0001, 16'd0, 64, 1'b1);
    check("R2 wrong type ignored", paused, 1'b1);
    send(MC, 16'h8808, 16'h0002, 16'd0, 64, 1'b1);
    check("R2 wrong opcode ignored", paused, 1'b1);
    send(48'h0180_C200_0002, 16'h8808, 16'h0001, 16'd0, 64, 1'b1);
    check("R1 near multicast ignored", paused, 1'b1);
    send(48'h0012_3456_7899, 16'h8808, 16'h0001, 16'd0, 64, 1'b1);
    check("R1 other unicast ignored", paused, 1'b1);
    cfg_tx_fc_en = 0;
    send(MC, 16'h8808, 16'h0001, 16'd0, 64, 1'b1);
    check("R4 disabled ignored", paused, 1'b1);
    cfg_tx_fc_en = 1;

    @(negedge clk); check("R8 inhibit while paused", tx_inhibit, 1'b1);
    tx_busy = 1; #1; check("R8 busy frame not held", tx_inhibit, 1'b0);
    tx_busy = 0; tx_fc_sel = 1; #1; check("R8 own fc frame not held", tx_inhibit, 1'b0);
    tx_fc_sel = 0;

    fifo_room = 0;
    pause_frame(OWN, 16'd0, 1'b0);
    fifo_room = 1;
    check("R7 unicast zero releases", paused, 1'b0);
    #1; check("R8 no inhibit when released", tx_inhibit, 1'b0);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule